// File: doc/BRIEF.md
# Presence-Detect Serial EEPROM Slave

This block is a 256-byte two-wire serial slave memory that holds the configuration table of a memory module. A host reads it over a two-wire bus whose data line is open-drain; here the data line is modelled as an input (`sda_i`) plus an output enable (`sda_oe`). When `sda_oe` is 1 the block pulls the line low. Both bus lines are oversampled on the system clock, and a small synchronizer turns them into rise, fall, START and STOP events.

The table splits into two halves. The low half (bytes 0 to 127) is filled at reset from an arithmetic preset: byte i is `(i*PAT_MUL + PAT_ADD) mod 256`, with defaults 37 and 11, and byte 63 holds the checksum instead. That checksum is the low eight bits of the unsigned sum of bytes 0 to 62. The low half is locked. The host may write it and the writes are acknowledged, but the data is dropped. The high half (bytes 128 to 255) resets to 0xFF and is freely writable.

After reset, a scanner walks bytes 0 to 63 once and raises `csum_ok` when the stored checksum matches the sum. The protocol engine is one enumerated state machine with these states:
- `ST_IDLE`: waiting for a START.
- `ST_DEV`: receiving the device byte. Goes to `ST_DEV_ACK` on an address match, otherwise to `ST_IGNORE`.
- `ST_DEV_ACK`: acknowledging the device byte. Goes to `ST_RDAT` for a read, or to `ST_WORD` for a write.
- `ST_WORD`: receiving the word address. Goes to `ST_WORD_ACK`.
- `ST_WORD_ACK`: acknowledging the word address. Goes to `ST_WDAT`.
- `ST_WDAT`: receiving a data byte. Goes to `ST_WDAT_ACK`.
- `ST_WDAT_ACK`: acknowledging the data byte. Goes back to `ST_WDAT`.
- `ST_RDAT`: shifting out a byte. Goes to `ST_RACK`.
- `ST_RACK`: sampling the host's acknowledge. Goes to `ST_RDAT` if the host acknowledged, or to `ST_IGNORE` if it did not.
- `ST_IGNORE`: the block stays silent.

From any state, a STOP leads to `ST_IDLE` and a START leads to `ST_DEV`.

Top module: `eep_spd`

## Requirements
- R1: While reset is asserted and directly after it, `sda_oe` is 0 and `csum_ok` is 0.
- R2: The block acknowledges a device byte only when its upper seven bits equal `1010`, then `0`, then `strap[1]`, then `strap[0]`. The lowest bit is read (1) or write (0). Any other device byte is not acknowledged, and the block stays silent until the next START or STOP.
- R3: In a write, the byte after the word address is stored at that address when the address is 128 or above, and the byte is acknowledged.
- R4: A data byte written to an address below 128 is acknowledged, but the stored byte keeps its preset value.
- R5: A random read works as follows: a write of the word address, then a repeated START with a read device byte. It returns the byte stored at that address, MSB first.
- R6: During a read, each byte sent advances the pointer by one, and address 255 wraps to 0.
- R7: During a write, each data byte advances the pointer by one, with the same wrap. Bytes that wrap into the locked half are acknowledged and dropped.
- R8: A host NACK ends a read, and the block releases the data line until the next START or STOP. A STOP or START in mid-byte returns the state machine to address reception.
- R9: After reset, byte i below 128 reads `(i*37+11) mod 256`, except byte 63. Byte 63 reads the low 8 bits of the sum of bytes 0 to 62. Bytes 128 to 255 read 0xFF.
- R10: `csum_ok` is 0 for the 64 clock cycles of the scan after reset. It then holds 1 when byte 63 equals the sum. Writes to the locked half cannot change it.
- R11: `sda_oe` changes only in response to a clock-line fall, a START or a STOP, so it never moves while the clock line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 2 | Board straps forming the two low address bits |
| csum_ok | output | 1 | Stored checksum matches bytes 0 to 62 |

## Verification
A wrong state register shows at the ports within one bus bit. A missed acknowledge appears at the ninth clock pulse of a byte, and a stray pull-down appears as a corrupted data bit or a stuck line. A pointer off by one shows in the very next byte returned by a sequential read, so the sweep reads the whole table and one byte past the wrap. The locked half is checked by reading back after a write, and the address decoder is swept across all four strap settings and a range of neighbouring addresses.

// File: rtl/eep_spd_pkg.sv
package eep_spd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_IGNORE
    } eep_state_e;

    // Preset content of one locked byte, before the checksum slot is filled.
    function automatic logic [7:0] pattern_byte(input int idx, input int mul, input int add);
        int v;
        v = idx * mul + add;
        return v[7:0];
    endfunction

    // Low eight bits of the sum of the first `count` preset bytes.
    function automatic logic [7:0] pattern_sum(input int count, input int mul, input int add);
        logic [7:0] s;
        s = '0;
        for (int i = 0; i < count; i++) begin
            s = s + pattern_byte(i, mul, add);
        end
        return s;
    endfunction

endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_sync;
    logic [1:0] sda_sync;
    logic       scl_prev;
    logic       sda_prev;
    logic       scl_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_prev <= scl_sync[1];
            sda_prev <= sda_sync[1];
        end
    end

    assign scl_lvl   = scl_sync[1];
    assign sda_lvl   = sda_sync[1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W     = 8,
    parameter int LOCK_SPLIT = 128,
    parameter int CSUM_IDX   = 63,
    parameter int PAT_MUL    = 37,
    parameter int PAT_ADD    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);
    import eep_spd_pkg::*;

    localparam int         DEPTH = 1 << ADDR_W;
    localparam logic [7:0] CSUM  = pattern_sum(CSUM_IDX, PAT_MUL, PAT_ADD);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i >= LOCK_SPLIT)    mem[i] <= 8'hFF;
                else if (i == CSUM_IDX) mem[i] <= CSUM;
                else                    mem[i] <= pattern_byte(i, PAT_MUL, PAT_ADD);
            end
        end else if (we && (int'(waddr) >= LOCK_SPLIT)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/eep_csum_scan.sv
module eep_csum_scan #(
    parameter int ADDR_W   = 8,
    parameter int CSUM_IDX = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              csum_ok,
    output logic              scan_done
);
    localparam int              IW      = $clog2(CSUM_IDX + 1);
    localparam logic [IW-1:0]   IDX_END = IW'(CSUM_IDX);

    logic [IW-1:0] idx;
    logic [7:0]    acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            acc       <= '0;
            csum_ok   <= 1'b0;
            scan_done <= 1'b0;
        end else if (!scan_done) begin
            if (idx == IDX_END) begin
                csum_ok   <= (acc == rd_data);
                scan_done <= 1'b1;
            end else begin
                acc <= acc + rd_data;
                idx <= idx + 1'b1;
            end
        end
    end

    assign rd_addr = ADDR_W'(idx);
endmodule

// File: rtl/eep_spd.sv
module eep_spd #(
    parameter int         ADDR_W     = 8,
    parameter int         LOCK_SPLIT = 128,
    parameter int         CSUM_IDX   = 63,
    parameter int         PAT_MUL    = 37,
    parameter int         PAT_ADD    = 11,
    parameter logic [4:0] DEV_PREFIX = 5'b10100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap,
    output logic       csum_ok
);
    import eep_spd_pkg::*;

    localparam logic [3:0]        BITS_FULL = 4'd8;
    localparam logic [ADDR_W-1:0] PTR_ONE   = ADDR_W'(1);

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    eep_line_mon u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_state_e        state, state_nx;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [6:0]        txreg;
    logic [ADDR_W-1:0] ptr;
    logic              acked;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] scan_addr;
    logic [7:0]        scan_data;
    logic              scan_done;
    logic              full;
    logic              dev_match;
    logic              mem_we;
    logic              is_ack_nx;
    logic              in_ack;

    assign full      = (bitcnt == BITS_FULL);
    assign dev_match = (shreg[7:1] == {DEV_PREFIX, strap});
    assign mem_we    = (state == ST_WDAT) && scl_fall && full && !start_det && !stop_det;
    assign is_ack_nx = (state_nx == ST_DEV_ACK) || (state_nx == ST_WORD_ACK) || (state_nx == ST_WDAT_ACK);
    assign in_ack    = (state == ST_DEV_ACK) || (state == ST_WORD_ACK) || (state == ST_WDAT_ACK);

    eep_store #(
        .ADDR_W     (ADDR_W),
        .LOCK_SPLIT (LOCK_SPLIT),
        .CSUM_IDX   (CSUM_IDX),
        .PAT_MUL    (PAT_MUL),
        .PAT_ADD    (PAT_ADD)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (ptr),
        .wdata   (shreg),
        .raddr_a (ptr),
        .rdata_a (rd_data),
        .raddr_b (scan_addr),
        .rdata_b (scan_data)
    );

    eep_csum_scan #(
        .ADDR_W   (ADDR_W),
        .CSUM_IDX (CSUM_IDX)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (scan_addr),
        .rd_data   (scan_data),
        .csum_ok   (csum_ok),
        .scan_done (scan_done)
    );

    // Next-state decision
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_nx = state;
                ST_DEV:      if (scl_fall && full) state_nx = dev_match ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:  if (scl_fall) state_nx = shreg[0] ? ST_RDAT : ST_WORD;
                ST_WORD:     if (scl_fall && full) state_nx = ST_WORD_ACK;
                ST_WORD_ACK: if (scl_fall) state_nx = ST_WDAT;
                ST_WDAT:     if (scl_fall && full) state_nx = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) state_nx = ST_WDAT;
                ST_RDAT:     if (scl_fall && full) state_nx = ST_RACK;
                ST_RACK:     if (scl_fall) state_nx = acked ? ST_RDAT : ST_IGNORE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath and bus output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            txreg  <= '0;
            ptr    <= '0;
            acked  <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            if (scl_rise) begin
                if ((state == ST_DEV || state == ST_WORD || state == ST_WDAT) && !full) begin
                    shreg  <= {shreg[6:0], sda_lvl};
                    bitcnt <= bitcnt + 4'd1;
                end
                if (state == ST_RDAT && !full) bitcnt <= bitcnt + 4'd1;
                if (state == ST_RACK) acked <= ~sda_lvl;
            end
            if (scl_fall) begin
                if (in_ack) begin
                    sda_oe <= 1'b0;
                    bitcnt <= '0;
                end
                if (is_ack_nx && state_nx != state) begin
                    sda_oe <= 1'b1;
                    bitcnt <= '0;
                end
                if (state == ST_WORD && full) ptr <= shreg[ADDR_W-1:0];
                if (mem_we) ptr <= ptr + PTR_ONE;
                if (state_nx == ST_RDAT && state != ST_RDAT) begin
                    txreg  <= rd_data[6:0];
                    sda_oe <= ~rd_data[7];
                    ptr    <= ptr + PTR_ONE;
                    bitcnt <= '0;
                end else if (state == ST_RDAT && state_nx == ST_RDAT && bitcnt != 4'd0) begin
                    txreg  <= {txreg[5:0], 1'b0};
                    sda_oe <= ~txreg[6];
                end
                if (state == ST_RDAT && state_nx == ST_RACK) sda_oe <= 1'b0;
                if (state_nx == ST_IGNORE) sda_oe <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/eep_spd_chk.sv
module eep_spd_chk (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sda_oe,
    input eep_spd_pkg::eep_state_e state,
    input logic                    line_evt,
    input logic                    scan_done,
    input logic                    csum_ok
);
    import eep_spd_pkg::*;

    // R2 / R8: silent when not addressed or after a NACK
    a_r2_silent_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

    // R8: line released while the host acknowledges
    a_r8_release_in_rack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK) |-> !sda_oe);

    // R11: output enable moves only after a clock fall, START or STOP
    a_r11_oe_on_events: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(line_evt));

    // R10: no valid flag before the scan has finished
    a_r10_low_before_scan: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_done |-> !csum_ok);

    // R10: flag and done hold once the scan is over
    a_r10_steady_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> (scan_done && $stable(csum_ok)));
endmodule

bind eep_spd eep_spd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .state     (state),
    .line_evt  (scl_fall | start_det | stop_det),
    .scan_done (scan_done),
    .csum_ok   (csum_ok)
);

// File: tb/eep_spd_tb_top.sv
`timescale 1ns/1ps
module eep_spd_tb_top;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       sda_oe;
    logic       csum_ok;
    wire        sda_bus = sda_m & ~sda_oe;

    int         checks = 0;
    int         errors = 0;
    int         oe_viol = 0;
    bit         finished = 1'b0;
    logic [7:0] model [256];

    always #2.5 clk = ~clk;

    eep_spd dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .sda_oe  (sda_oe),
        .strap   (strap),
        .csum_ok (csum_ok)
    );

    // R11 monitor: output enable must not move while the clock line stays high
    logic scl_prev_tb = 1'b1;
    logic oe_prev_tb  = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev_tb && (sda_oe !== oe_prev_tb)) oe_viol++;
        scl_prev_tb = scl_m;
        oe_prev_tb  = sda_oe;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        repeat (Q) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {4'b1010, 1'b0, strap, rw};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick();
        scl_m = 1'b1; tick();
        sda_m = 1'b0; tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick();
        scl_m = 1'b1; tick();
        sda_m = 1'b1; tick();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick();
        scl_m = 1'b1; tick(); tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick();
        scl_m = 1'b1; tick();
        b = sda_bus; tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            d[i] = x;
        end
        send_bit(~give_ack);
    endtask

    task automatic set_ptr(input logic [7:0] a, input string req);
        logic ack;
        bus_start();
        send_byte(dev(1'b0), ack); chk(req, "device write ack", int'(ack), 1);
        send_byte(a, ack);         chk(req, "word address ack", int'(ack), 1);
    endtask

    task automatic read_run(input logic [7:0] a, input int n, input string req);
        logic       ack;
        logic [7:0] d;
        logic [7:0] idx;
        set_ptr(a, req);
        bus_start();
        send_byte(dev(1'b1), ack); chk(req, "device read ack", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            idx = a + 8'(k);
            recv_byte(d, k != n - 1);
            chk(req, $sformatf("read byte %0h", idx), int'(d), int'(model[idx]));
        end
        bus_stop();
    endtask

    task automatic write_run(input logic [7:0] a, input int n, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2, input string req);
        logic       ack;
        logic [7:0] d;
        logic [7:0] idx;
        set_ptr(a, req);
        for (int k = 0; k < n; k++) begin
            d   = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            idx = a + 8'(k);
            send_byte(d, ack);
            chk(req, "data ack", int'(ack), 1);
            if (idx >= 8'd128) model[idx] = d;
        end
        bus_stop();
    endtask

    initial begin : main
        logic       ack;
        logic       x;
        logic [7:0] d;
        logic [7:0] sum;
        sum = 8'h00;
        for (int i = 0; i < 256; i++) model[i] = (i < 128) ? 8'((i * 37 + 11) % 256) : 8'hFF;
        for (int i = 0; i < 63; i++) sum = sum + model[i];
        model[63] = sum;

        // R1: reset state
        repeat (5) @(negedge clk);
        chk("R1", "sda_oe in reset", int'(sda_oe), 0);
        chk("R1", "csum_ok in reset", int'(csum_ok), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10", "csum_ok during scan", int'(csum_ok), 0);
        chk("R1", "sda_oe after reset", int'(sda_oe), 0);
        repeat (90) @(negedge clk);
        chk("R10", "csum_ok after scan", int'(csum_ok), 1);

        // R9 preset and R6 increment with wrap: whole table plus one byte
        read_run(8'h00, 257, "R9/R6");

        // R2: address decode over all straps and neighbouring addresses
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int a = 'h40; a < 'h60; a++) begin
                bus_start();
                send_byte({7'(a), 1'b0}, ack);
                chk("R2", $sformatf("ack addr %0h strap %0d", a, s), int'(ack),
                    int'(a == (('h50) | s)));
                bus_stop();
            end
        end
        strap = 2'b01;
        tick();

        // R3 write and R5 random read back
        write_run(8'h90, 1, 8'hA5, 8'h00, 8'h00, "R3");
        read_run(8'h90, 1, "R5");

        // R4: locked write acknowledged, content unchanged
        write_run(8'h10, 1, 8'h00, 8'h00, 8'h00, "R4");
        read_run(8'h10, 1, "R4");
        write_run(8'h3F, 1, 8'h5A, 8'h00, 8'h00, "R4");
        read_run(8'h3F, 1, "R4");
        chk("R10", "csum_ok after locked writes", int'(csum_ok), 1);

        // R7: multi-byte write wrapping into the locked half
        write_run(8'hFE, 3, 8'h11, 8'h22, 8'h33, "R7");
        read_run(8'hFE, 3, "R7");

        // R8: host NACK ends the read, block silent afterwards
        set_ptr(8'h90, "R8");
        bus_start();
        send_byte(dev(1'b1), ack); chk("R8", "read ack", int'(ack), 1);
        recv_byte(d, 1'b0);        chk("R8", "byte before nack", int'(d), int'(model[8'h90]));
        recv_byte(d, 1'b0);        chk("R8", "line idle after nack", int'(d), 'hFF);
        bus_start();
        send_byte(dev(1'b0), ack); chk("R8", "ack after repeated start", int'(ack), 1);
        send_byte(8'h20, ack);     chk("R8", "word ack after restart", int'(ack), 1);
        bus_stop();

        // R8: STOP in the middle of a device byte
        bus_start();
        for (int i = 7; i >= 4; i--) send_bit(dev(1'b0)>>i);
        bus_stop();
        read_run(8'h91, 1, "R8");

        // R8: wrong device byte leaves the line released for the next byte
        bus_start();
        send_byte(8'hAE, ack); chk("R8", "no ack for foreign address", int'(ack), 0);
        for (int i = 0; i < 8; i++) begin
            recv_bit(x);
            chk("R8", "released after foreign address", int'(x), 1);
        end
        bus_stop();

        chk("R11", "sda_oe moved while clock high", oe_viol, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule